// File: doc/BRIEF.md
# Bi-predictive Quarter-pel Writeback for 8x8 Luma Blocks

This block produces the final luma sample for the diagonal quarter-pel position that lies between the centre half-pel sample and the horizontal half-pel sample. An upstream filter stage delivers one pair of half-pel values per pixel: the centre sample and the horizontal sample. The block takes them in raster order over an 8x8 block, forms their round-half-up mean, and stores the result in a byte-addressed destination buffer.

The destination can be updated in one of two modes. In direct mode the quarter-pel value overwrites the destination pixel. In averaging mode the destination already holds a first prediction. The block reads each stored pixel, averages it with the new quarter-pel value using the same rounding, and writes the mean back to the same address. This folds the second prediction of a bi-predicted block into the first.

A start pulse latches the destination base address, the row stride and the mode for one block. Pixels then arrive one per cycle under a valid/ready handshake, and a done pulse marks the last write.

Top module: `qpel_bipred_wb`

## Requirements
- R1: For each pixel, the quarter-pel value is q = (centre + horizontal + 1) >> 1, computed on unsigned 8-bit inputs without overflow.
- R2: In averaging mode (mode input 1 at start), the written byte is (old + q + 1) >> 1. Here old is the byte the destination held at that address before the block began.
- R3: In direct mode (mode input 0 at start), the written byte is q and the read enable never asserts during the block.
- R4: The k-th accepted pixel (k = 0..63) is written to base + (k >> 3) * stride + (k & 7), modulo 2^AW.
- R5: The read for an accepted pixel is issued in the cycle of acceptance. The read data is taken one cycle later. The write for that pixel occurs in the cycle after acceptance, at the same address as its read.
- R6: Exactly 64 writes occur per block, and done pulses for one cycle together with the 64th write. After the 64th acceptance, ready stays low until a new start.
- R7: A start pulse while a block is in progress is ignored. Changes to base, stride or mode after the accepted start have no effect on that block.
- R8: During and right after reset, ready, busy, done, read enable and write enable are all low, and no write occurs until a start.
- R9: Ready is high only while a block is active and fewer than 64 pixels have been accepted. Gaps in valid delay writes but do not change their values or order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a block; latches base, stride and mode when idle |
| mode_avg_i | input | 1 | 0 = direct write, 1 = average with stored pixel |
| dst_base_i | input | AW | Destination address of pixel (0,0) |
| stride_i | input | AW | Address distance between rows |
| in_valid_i | input | 1 | Half-pel pair present |
| in_ready_o | output | 1 | Block accepts a pair this cycle |
| ctr_i | input | PW | Centre half-pel sample |
| hor_i | input | PW | Horizontal half-pel sample |
| rd_en_o | output | 1 | Destination read request |
| rd_addr_o | output | AW | Destination read address |
| rd_data_i | input | PW | Read data, valid one cycle after rd_en_o |
| wr_en_o | output | 1 | Destination write strobe |
| wr_addr_o | output | AW | Destination write address |
| wr_data_o | output | PW | Destination write data |
| busy_o | output | 1 | Block in progress |
| done_o | output | 1 | One-cycle pulse with the last write |

## Verification
A corrupted column or row-base register shows up as a wrong write address on the very next write. A stray pixel counter value shows up as a write count other than 64, or as a done pulse on the wrong write. Either appears within one block. A mode register that flips, or a read-data alignment that slips by one cycle, gives wrong bytes at the first written pixel in averaging mode. A read enable in direct mode is seen as soon as that pixel is accepted. The bench compares every write against a snapshot of the destination taken when the block starts. It also checks the done timing, the write count and the absence of reads in direct mode at every cycle.

// File: rtl/qpel_pkg.sv
package qpel_pkg;
  typedef enum logic {
    WB_DIRECT = 1'b0,
    WB_AVG    = 1'b1
  } wb_mode_e;
endpackage

// File: rtl/qpel_round_avg.sv
module qpel_round_avg #(
  parameter int PW = 8
) (
  input  logic [PW-1:0] a_i,
  input  logic [PW-1:0] b_i,
  output logic [PW-1:0] y_o
);
  localparam int SW = PW + 1;

  logic [SW-1:0] sum;

  always_comb begin
    sum = SW'(a_i) + SW'(b_i) + SW'(1);
    y_o = sum[SW-1:1];
  end

  // R1: a rounded mean never leaves the interval spanned by its operands
  always_comb begin
    assert_mean_in_range_R1: assert (((y_o >= a_i) && (y_o <= b_i)) ||
                                     ((y_o >= b_i) && (y_o <= a_i)))
      else $error("mean outside operand range");
  end
endmodule

// File: rtl/qpel_raster_addr.sv
module qpel_raster_addr #(
  parameter int AW    = 12,
  parameter int BLK_W = 8,
  parameter int BLK_H = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] stride_i,
  input  logic          adv_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o,
  output logic          empty_o
);
  localparam int NPIX = BLK_W * BLK_H;
  localparam int CW   = $clog2(BLK_W);
  localparam int NW   = $clog2(NPIX + 1);

  logic [CW-1:0] col_q,      col_d;
  logic [NW-1:0] cnt_q,      cnt_d;
  logic [AW-1:0] row_base_q, row_base_d;
  logic [AW-1:0] stride_q,   stride_d;

  always_comb begin
    col_d      = col_q;
    cnt_d      = cnt_q;
    row_base_d = row_base_q;
    stride_d   = stride_q;
    if (load_i) begin
      col_d      = '0;
      cnt_d      = '0;
      row_base_d = base_i;
      stride_d   = stride_i;
    end else if (adv_i) begin
      cnt_d = cnt_q + NW'(1);
      if (col_q == CW'(BLK_W - 1)) begin
        col_d      = '0;
        row_base_d = row_base_q + stride_q;
      end else begin
        col_d = col_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q      <= '0;
      cnt_q      <= NW'(NPIX);
      row_base_q <= '0;
      stride_q   <= '0;
    end else if (load_i || adv_i) begin
      col_q      <= col_d;
      cnt_q      <= cnt_d;
      row_base_q <= row_base_d;
      stride_q   <= stride_d;
    end
  end

  assign addr_o  = row_base_q + AW'(col_q);
  assign last_o  = (cnt_q == NW'(NPIX - 1));
  assign empty_o = (cnt_q == NW'(NPIX));

  // R6: the pixel counter never runs past one block
  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= NW'(NPIX));

  // R6: no advance once the block is exhausted
  assert_no_adv_when_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |-> !empty_o);
endmodule

// File: rtl/qpel_bipred_wb.sv
module qpel_bipred_wb
  import qpel_pkg::*;
#(
  parameter int AW    = 12,
  parameter int PW    = 8,
  parameter int BLK_W = 8,
  parameter int BLK_H = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          mode_avg_i,
  input  logic [AW-1:0] dst_base_i,
  input  logic [AW-1:0] stride_i,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [PW-1:0] ctr_i,
  input  logic [PW-1:0] hor_i,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [PW-1:0] rd_data_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [PW-1:0] wr_data_o,
  output logic          busy_o,
  output logic          done_o
);
  logic          busy_q, busy_d;
  wb_mode_e      mode_q, mode_d;
  logic          wr_en_q, wr_en_d;
  logic [AW-1:0] wr_addr_q, wr_addr_d;
  logic [PW-1:0] qpel_q, qpel_d;
  logic          last_q, last_d;

  logic          load;
  logic          accept;
  logic          blk_done;
  logic [AW-1:0] pix_addr;
  logic          pix_last;
  logic          pix_empty;
  logic [PW-1:0] qpel_new;
  logic [PW-1:0] merged;

  qpel_raster_addr #(.AW(AW), .BLK_W(BLK_W), .BLK_H(BLK_H)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .base_i   (dst_base_i),
    .stride_i (stride_i),
    .adv_i    (accept),
    .addr_o   (pix_addr),
    .last_o   (pix_last),
    .empty_o  (pix_empty)
  );

  qpel_round_avg #(.PW(PW)) u_qpel (
    .a_i (ctr_i),
    .b_i (hor_i),
    .y_o (qpel_new)
  );

  qpel_round_avg #(.PW(PW)) u_merge (
    .a_i (rd_data_i),
    .b_i (qpel_q),
    .y_o (merged)
  );

  assign load       = !busy_q && start_i;
  assign in_ready_o = busy_q && !pix_empty;
  assign accept     = in_ready_o && in_valid_i;
  assign blk_done   = wr_en_q && last_q;

  always_comb begin
    busy_d = busy_q;
    mode_d = mode_q;
    if (load) begin
      busy_d = 1'b1;
      mode_d = wb_mode_e'(mode_avg_i);
    end else if (blk_done) begin
      busy_d = 1'b0;
    end
  end

  always_comb begin
    wr_en_d   = accept;
    wr_addr_d = wr_addr_q;
    qpel_d    = qpel_q;
    last_d    = last_q;
    if (accept) begin
      wr_addr_d = pix_addr;
      qpel_d    = qpel_new;
      last_d    = pix_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mode_q <= WB_DIRECT;
    end else begin
      busy_q <= busy_d;
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      qpel_q    <= '0;
      last_q    <= 1'b0;
    end else begin
      wr_en_q   <= wr_en_d;
      wr_addr_q <= wr_addr_d;
      qpel_q    <= qpel_d;
      last_q    <= last_d;
    end
  end

  assign rd_en_o   = accept && (mode_q == WB_AVG);
  assign rd_addr_o = pix_addr;
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = (mode_q == WB_AVG) ? merged : qpel_q;
  assign busy_o    = busy_q;
  assign done_o    = blk_done;

  // R5: every read is answered by a write to the same address one cycle later
  assert_read_pairs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |=> (wr_en_o && (wr_addr_o == $past(rd_addr_o))));

  // R5: every accepted pixel is written in the following cycle
  assert_accept_then_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o) |=> wr_en_o);

  // R3: in direct mode a write is never preceded by a read
  assert_direct_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && (mode_q == WB_DIRECT)) |-> !$past(rd_en_o));

  // R6: done comes with a write and closes the block
  assert_done_with_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> wr_en_o);
  assert_done_ends_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!in_ready_o && !wr_en_o && !busy_o));

  // R7: configuration is stable while a block runs
  assert_mode_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_o) && busy_o) |-> $stable(mode_q));

  // R9: ready only while busy
  assert_ready_needs_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o |-> busy_o);
endmodule

// File: tb/sim_qpel_bipred_wb.sv
`timescale 1ns/1ps
module sim_qpel_bipred_wb;
  localparam int AW   = 12;
  localparam int PW   = 8;
  localparam int MSZ  = 1 << AW;
  localparam int NPIX = 64;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic          mode_avg_i;
  logic [AW-1:0] dst_base_i;
  logic [AW-1:0] stride_i;
  logic          in_valid_i;
  logic          in_ready_o;
  logic [PW-1:0] ctr_i;
  logic [PW-1:0] hor_i;
  logic          rd_en_o;
  logic [AW-1:0] rd_addr_o;
  logic [PW-1:0] rd_data_i;
  logic          wr_en_o;
  logic [AW-1:0] wr_addr_o;
  logic [PW-1:0] wr_data_o;
  logic          busy_o;
  logic          done_o;

  qpel_bipred_wb #(.AW(AW), .PW(PW)) u0 (.*);

  int checks = 0;
  int errors = 0;
  logic [7:0] mem [MSZ];
  int exp_addr [NPIX];
  int exp_data [NPIX];
  int wr_k;
  int done_cnt;
  bit cur_avg;
  bit active;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (rd_en_o) rd_data_i <= mem[rd_addr_o];
    if (wr_en_o) mem[wr_addr_o] <= wr_data_o;
  end

  function automatic int f_avg(input int a, input int b);
    return (a + b + 1) >> 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // write monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_en_o && !cur_avg) chk(1'b0, "R3 read in direct mode", 1, 0);
      if (wr_en_o) begin
        if (!active || wr_k >= NPIX) begin
          chk(1'b0, "R6 write outside block", wr_k, NPIX);
        end else begin
          chk(int'(wr_addr_o) == exp_addr[wr_k], "R4 address", int'(wr_addr_o), exp_addr[wr_k]);
          chk(int'(wr_data_o) == exp_data[wr_k],
              cur_avg ? "R2 averaged byte" : "R1/R3 direct byte",
              int'(wr_data_o), exp_data[wr_k]);
          wr_k++;
        end
      end
      if (done_o) begin
        done_cnt++;
        chk(wr_en_o && wr_k == NPIX, "R6 done with 64th write", wr_k, NPIX);
      end
    end
  end

  // pattern: 0 random, 1 all max, 2 minimal rounding, 3 max/zero mix
  task automatic run_block(input bit avg, input int base, input int stride,
                           input int pat, input int gap_pct, input bit disturb);
    logic [7:0] cv [NPIX];
    logic [7:0] hv [NPIX];
    int k;
    int guard;
    for (int i = 0; i < NPIX; i++) begin
      int a;
      int q;
      a = (base + (i >> 3) * stride + (i & 7)) % MSZ;
      case (pat)
        1: begin cv[i] = 8'hFF; hv[i] = 8'hFF; mem[a] = 8'h00; end
        2: begin cv[i] = 8'h00; hv[i] = 8'h01; mem[a] = 8'h00; end
        3: begin cv[i] = 8'hFF; hv[i] = 8'h00; mem[a] = 8'hFF; end
        default: begin cv[i] = 8'($urandom); hv[i] = 8'($urandom); end
      endcase
      q = f_avg(cv[i], hv[i]);
      exp_addr[i] = a;
      exp_data[i] = avg ? f_avg(mem[a], q) : q;
    end
    wr_k = 0;
    done_cnt = 0;
    cur_avg = avg;
    active = 1'b1;
    @(negedge clk);
    start_i    = 1'b1;
    mode_avg_i = avg;
    dst_base_i = AW'(base);
    stride_i   = AW'(stride);
    @(negedge clk);
    start_i = 1'b0;
    if (disturb) begin
      mode_avg_i = !avg;
      dst_base_i = AW'(base + 100);
      stride_i   = AW'(stride + 3);
    end
    k = 0;
    guard = 0;
    while (k < NPIX && guard < 5000) begin
      in_valid_i = ($urandom % 100) >= gap_pct;
      ctr_i = cv[k];
      hor_i = hv[k];
      if (disturb && k == 20) start_i = 1'b1;
      @(posedge clk);
      if (in_valid_i && in_ready_o) k++;
      @(negedge clk);
      start_i = 1'b0;
      guard++;
    end
    in_valid_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(wr_k == NPIX, "R6 write count", wr_k, NPIX);
    chk(done_cnt == 1, "R6 done pulse count", done_cnt, 1);
    chk(!in_ready_o && !busy_o, "R9 idle after block", int'(in_ready_o), 0);
    active = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < MSZ; i++) mem[i] = 8'($urandom);
    rst_n = 1'b0; start_i = 1'b0; mode_avg_i = 1'b0; in_valid_i = 1'b0;
    dst_base_i = '0; stride_i = '0; ctr_i = '0; hor_i = '0; rd_data_i = '0;
    wr_k = 0; done_cnt = 0; cur_avg = 1'b0; active = 1'b0;
    repeat (3) @(negedge clk);
    chk(!in_ready_o && !busy_o && !done_o, "R8 reset state", int'(busy_o), 0);
    chk(!rd_en_o && !wr_en_o, "R8 reset strobes", int'(wr_en_o), 0);
    rst_n = 1'b1;
    in_valid_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(!in_ready_o && !wr_en_o, "R8 idle until start", int'(in_ready_o), 0);
    in_valid_i = 1'b0;
    // directed corners
    run_block(1'b0, 16,  32, 1, 0,  1'b0);
    run_block(1'b1, 600, 40, 1, 0,  1'b0);
    run_block(1'b1, 1200, 8, 2, 30, 1'b0);
    run_block(1'b0, 2000, 64, 3, 0, 1'b0);
    run_block(1'b1, 2500, 16, 3, 10, 1'b0);
    run_block(1'b1, 4090, 24, 0, 0, 1'b0);  // address wrap R4
    run_block(1'b1, 300, 20, 0, 25, 1'b1);  // R7 disturbance
    run_block(1'b0, 900, 12, 0, 40, 1'b1);  // R7 disturbance
    // constrained random blocks
    for (int b = 0; b < 20; b++) begin
      run_block(1'($urandom), int'($urandom % MSZ), 8 + int'($urandom % 120),
                0, int'($urandom % 60), 1'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule